// File: doc/BRIEF.md
# Indexed Memory Subtract-with-Borrow Unit

This unit runs one instruction of a 4-bit controller: it subtracts a register operand and the carry flag from a nibble in data memory, writes the difference back to the same place, and then steps the index register that held the address. The opcode chooses which of the two index registers (X or Y) gives the destination address. A 2-bit field in the opcode chooses the subtrahend. It can be accumulator A, register B, or one of the two indexed memory nibbles.

The surrounding core holds the register file, the flags and the data memory. The unit samples the operand registers and the carry flag on the start edge. It then runs a fixed seven-cycle sequence over a plain synchronous nibble memory port. The memory returns read data one cycle after it sees the address. The unit gives the new C and Z values with a one-cycle write strobe, gives the next index value with its own write strobe, and marks completion with a done pulse. No data streams in or out, so every pin is a plain control or data pin and nothing can apply back-pressure. The core must keep memory and the index registers still while the unit is busy.

Top module: `idxsub_unit`

## Requirements
- R1: A start is taken only when the 12-bit opcode lies in 0xF38..0xF3F. Opcode bit 2 picks the destination index: 0 = X, 1 = Y. A start with any other opcode leaves the unit idle and produces no strobes.
- R2: Opcode bits 1:0 pick the subtrahend: 00 = A, 01 = B, 10 = nibble at X, 11 = nibble at Y. A memory subtrahend is read before the destination is written.
- R3: The nibble at the destination address becomes (M − r − C) mod 16. It is written with mem_we high for exactly one cycle, in the fifth cycle after the start edge.
- R4: flag_c is 1 when M < r + C, i.e. when a borrow occurs, and 0 otherwise. It is valid while flag_we is high, and flag_we is high in the same cycle as mem_we.
- R5: flag_z is 1 when the written nibble is 0 and 0 otherwise. It is valid while flag_we is high.
- R6: In the sixth cycle after the start edge, idx_we pulses for one cycle. idx_sel_y names the index used (1 = Y). idx_wdata is that index plus one, wrapping 0xFF to 0x00. This update touches no flag.
- R7: busy is high for cycles 1 to 7 after the start edge. done pulses for one cycle in cycle 7.
- R8: A start that comes while busy is high is ignored.
- R9: After reset, busy, done, mem_we, flag_we and idx_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction when idle |
| opcode | input | 12 | Instruction word |
| reg_a | input | 4 | Accumulator A value |
| reg_b | input | 4 | Register B value |
| idx_x | input | 8 | Index register X |
| idx_y | input | 8 | Index register Y |
| carry_in | input | 1 | Current carry flag |
| mem_addr | output | 8 | Registered memory address |
| mem_we | output | 1 | Registered memory write enable |
| mem_wdata | output | 4 | Registered memory write data |
| mem_rdata | input | 4 | Read data, one cycle after address |
| flag_we | output | 1 | Write strobe for C and Z |
| flag_c | output | 1 | New carry (borrow) flag |
| flag_z | output | 1 | New zero flag |
| idx_we | output | 1 | Write strobe for the index register |
| idx_sel_y | output | 1 | Index register to write: 1 = Y, 0 = X |
| idx_wdata | output | 8 | New index value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume that the core keeps memory and both index registers unchanged between a start and its done pulse. With that in place, the written nibble and the incremented address can be related to the address the unit drove. The bench's memory and register file change only through the unit's own strobes, and operand values are set only while the unit is idle. A few starts are deliberately raised mid-sequence, and some carry opcodes outside the range, to exercise the ignore rules without breaking that assumption.

// File: rtl/isb_pkg.sv
package isb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_SUBR = 3'd2,
    ST_DSTA = 3'd3,
    ST_CALC = 3'd4,
    ST_WRT  = 3'd5,
    ST_INC  = 3'd6,
    ST_FIN  = 3'd7
  } isb_state_e;

  typedef enum logic [1:0] {
    SRC_A  = 2'b00,
    SRC_B  = 2'b01,
    SRC_MX = 2'b10,
    SRC_MY = 2'b11
  } isb_src_e;
endpackage

// File: rtl/isb_decode.sv
module isb_decode #(
  parameter int OP_W = 12,
  parameter logic [OP_W-1:0] OP_BASE = 12'hF38
) (
  input  logic [OP_W-1:0] op,
  output logic            hit,
  output logic            use_y,
  output isb_pkg::isb_src_e src
);
  localparam int TAG_W = OP_W - 3;

  always_comb begin
    hit   = (op[OP_W-1:3] == OP_BASE[OP_W-1:3]);
    use_y = op[2];
    src   = isb_pkg::isb_src_e'(op[1:0]);
  end
endmodule

// File: rtl/isb_alu.sv
module isb_alu #(
  parameter int DAT_W = 4
) (
  input  logic [DAT_W-1:0] minuend,
  input  logic [DAT_W-1:0] subtr,
  input  logic             bin,
  output logic [DAT_W-1:0] diff,
  output logic             bout,
  output logic             zero
);
  logic [DAT_W:0] wide;

  always_comb begin
    wide = {1'b0, minuend} - {1'b0, subtr} - {{DAT_W{1'b0}}, bin};
    diff = wide[DAT_W-1:0];
    bout = wide[DAT_W];
    zero = (wide[DAT_W-1:0] == '0);
  end
endmodule

// File: rtl/isb_incr.sv
module isb_incr #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] cur,
  output logic [IDX_W-1:0] nxt
);
  localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  assign nxt = cur + ONE;
endmodule

// File: rtl/idxsub_unit.sv
module idxsub_unit #(
  parameter int IDX_W = 8,
  parameter int DAT_W = 4,
  parameter int OP_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OP_W-1:0]  opcode,
  input  logic [DAT_W-1:0] reg_a,
  input  logic [DAT_W-1:0] reg_b,
  input  logic [IDX_W-1:0] idx_x,
  input  logic [IDX_W-1:0] idx_y,
  input  logic             carry_in,
  output logic [IDX_W-1:0] mem_addr,
  output logic             mem_we,
  output logic [DAT_W-1:0] mem_wdata,
  input  logic [DAT_W-1:0] mem_rdata,
  output logic             flag_we,
  output logic             flag_c,
  output logic             flag_z,
  output logic             idx_we,
  output logic             idx_sel_y,
  output logic [IDX_W-1:0] idx_wdata,
  output logic             busy,
  output logic             done
);
  import isb_pkg::*;

  isb_state_e st;
  isb_src_e   dec_src, src_q;
  logic       dec_hit, dec_y;
  logic       y_q, c_q;
  logic [DAT_W-1:0] a_q, b_q, sub_q;
  logic [IDX_W-1:0] dst_q, src_addr, inc_val;
  logic [DAT_W-1:0] alu_diff;
  logic       alu_bout, alu_zero;
  logic       take;

  isb_decode #(.OP_W(OP_W)) u_dec (
    .op(opcode), .hit(dec_hit), .use_y(dec_y), .src(dec_src)
  );

  isb_alu #(.DAT_W(DAT_W)) u_alu (
    .minuend(mem_rdata), .subtr(sub_q), .bin(c_q),
    .diff(alu_diff), .bout(alu_bout), .zero(alu_zero)
  );

  isb_incr #(.IDX_W(IDX_W)) u_inc (.cur(dst_q), .nxt(inc_val));

  assign take     = start && dec_hit && (st == ST_IDLE);
  assign src_addr = (dec_src == SRC_MY) ? idx_y : idx_x;
  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      src_q     <= SRC_A;
      y_q       <= 1'b0;
      c_q       <= 1'b0;
      a_q       <= '0;
      b_q       <= '0;
      sub_q     <= '0;
      dst_q     <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      flag_we   <= 1'b0;
      flag_c    <= 1'b0;
      flag_z    <= 1'b0;
      idx_we    <= 1'b0;
      idx_sel_y <= 1'b0;
      idx_wdata <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (take) begin
          st       <= ST_LOAD;
          src_q    <= dec_src;
          y_q      <= dec_y;
          c_q      <= carry_in;
          a_q      <= reg_a;
          b_q      <= reg_b;
          dst_q    <= dec_y ? idx_y : idx_x;
          mem_addr <= src_addr;
        end
        ST_LOAD: st <= ST_SUBR;
        ST_SUBR: begin
          unique case (src_q)
            SRC_A:   sub_q <= a_q;
            SRC_B:   sub_q <= b_q;
            default: sub_q <= mem_rdata;
          endcase
          mem_addr <= dst_q;
          st       <= ST_DSTA;
        end
        ST_DSTA: st <= ST_CALC;
        ST_CALC: begin
          mem_wdata <= alu_diff;
          mem_we    <= 1'b1;
          flag_c    <= alu_bout;
          flag_z    <= alu_zero;
          flag_we   <= 1'b1;
          st        <= ST_WRT;
        end
        ST_WRT: begin
          mem_we    <= 1'b0;
          flag_we   <= 1'b0;
          idx_we    <= 1'b1;
          idx_sel_y <= y_q;
          idx_wdata <= inc_val;
          st        <= ST_INC;
        end
        ST_INC: begin
          idx_we <= 1'b0;
          st     <= ST_FIN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/isb_chk.sv
module isb_chk #(
  parameter int IDX_W = 8,
  parameter int DAT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [IDX_W-1:0] mem_addr,
  input logic             mem_we,
  input logic [DAT_W-1:0] mem_wdata,
  input logic             flag_we,
  input logic             flag_z,
  input logic             idx_we,
  input logic [IDX_W-1:0] idx_wdata,
  input logic             busy,
  input logic             done
);
  localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  // R7
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R4
  flags_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> mem_we);
  // R5
  zero_matches_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (flag_z == (mem_wdata == '0)));
  // R6
  index_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> idx_we);
  // R6
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |-> (idx_wdata == mem_addr + ONE));
  // R7
  done_after_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> done);
  // R8
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
endmodule

bind idxsub_unit isb_chk #(.IDX_W(IDX_W), .DAT_W(DAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
  .mem_we(mem_we), .mem_wdata(mem_wdata), .flag_we(flag_we),
  .flag_z(flag_z), .idx_we(idx_we), .idx_wdata(idx_wdata),
  .busy(busy), .done(done)
);

// File: tb/idxsub_unit_test.sv
`timescale 1ns/1ps
module idxsub_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [11:0] opcode = 12'h000;
  logic [3:0] a_r = 0, b_r = 0;
  logic [7:0] x_r = 0, y_r = 0;
  logic c_r = 0, z_r = 0;
  logic [3:0] mem [256];
  logic [3:0] rdata;
  logic [7:0] mem_addr, idx_wdata;
  logic [3:0] mem_wdata;
  logic mem_we, flag_we, flag_c, flag_z, idx_we, idx_sel_y, busy, done;

  int n_chk = 0, n_bad = 0;
  int ph = 0;
  int e_res, e_dst, e_idx;
  bit e_c, e_z, e_y;
  bit finished = 0;

  always #2.5 clk = ~clk;

  idxsub_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .reg_a(a_r), .reg_b(b_r), .idx_x(x_r), .idx_y(y_r), .carry_in(c_r),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(rdata), .flag_we(flag_we), .flag_c(flag_c), .flag_z(flag_z),
    .idx_we(idx_we), .idx_sel_y(idx_sel_y), .idx_wdata(idx_wdata),
    .busy(busy), .done(done)
  );

  // environment: memory and register file, changed only by the unit's strobes
  always @(posedge clk) begin
    rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (flag_we) begin c_r <= flag_c; z_r <= flag_z; end
    if (idx_we) begin
      if (idx_sel_y) y_r <= idx_wdata; else x_r <= idx_wdata;
    end
  end

  // behavioural cycle model
  always @(posedge clk) begin
    if (!rst_n) ph <= 0;
    else if (ph == 0) begin
      if (start && opcode >= 12'hF38 && opcode <= 12'hF3F) begin
        int sv, d, dst;
        dst = opcode[2] ? int'(y_r) : int'(x_r);
        case (opcode[1:0])
          2'b00: sv = a_r;
          2'b01: sv = b_r;
          2'b10: sv = mem[x_r];
          default: sv = mem[y_r];
        endcase
        d = int'(mem[dst]) - sv - int'(c_r);
        e_res <= d & 15;
        e_c   <= (d < 0);
        e_z   <= ((d & 15) == 0);
        e_dst <= dst;
        e_idx <= (dst + 1) % 256;
        e_y   <= opcode[2];
        ph    <= 1;
      end
    end else ph <= (ph == 7) ? 0 : ph + 1;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compared on every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(busy == (ph != 0), "R7 busy", busy, ph != 0);
    chk(done == (ph == 7), "R7 done", done, ph == 7);
    chk(mem_we == (ph == 5), "R3 mem_we", mem_we, ph == 5);
    chk(flag_we == (ph == 5), "R4 flag_we", flag_we, ph == 5);
    chk(idx_we == (ph == 6), "R6 idx_we", idx_we, ph == 6);
    if (ph == 5) begin
      chk(mem_addr == e_dst, "R1 dest addr", mem_addr, e_dst);
      chk(mem_wdata == e_res, "R3 data", mem_wdata, e_res);
      chk(flag_c == e_c, "R4 carry", flag_c, e_c);
      chk(flag_z == e_z, "R5 zero", flag_z, e_z);
    end
    if (ph == 6) begin
      chk(idx_wdata == e_idx, "R6 index", idx_wdata, e_idx);
      chk(idx_sel_y == e_y, "R6 sel", idx_sel_y, e_y);
    end
  end

  task automatic run_op(logic [11:0] op);
    @(negedge clk);
    opcode = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 4'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !mem_we && !flag_we && !idx_we, "R9 reset", busy, 0);
    rst_n = 1'b1;

    // R1 R3 R6 X form, r=B
    x_r = 8'h50; mem[8'h50] = 4'd6; b_r = 4'd2; c_r = 0;
    run_op(12'hF39);
    chk(mem[8'h50] == 4, "R3 example x", mem[8'h50], 4);
    chk(x_r == 8'h51, "R6 x step", x_r, 8'h51);
    chk(c_r == 0 && z_r == 0, "R4 R5 flags x", {c_r, z_r}, 0);

    // R6 wrap, Y form r=A with carry
    y_r = 8'hFF; mem[8'hFF] = 4'd7; a_r = 4'd2; c_r = 1;
    run_op(12'hF3C);
    chk(mem[8'hFF] == 4, "R3 example y", mem[8'hFF], 4);
    chk(y_r == 8'h00, "R6 wrap", y_r, 0);
    chk(c_r == 0, "R4 no borrow", c_r, 0);

    // R4 borrow
    x_r = 8'h10; mem[8'h10] = 4'd1; a_r = 4'd3; c_r = 0;
    run_op(12'hF38);
    chk(mem[8'h10] == 4'hE, "R4 borrow data", mem[8'h10], 4'hE);
    chk(c_r == 1, "R4 borrow flag", c_r, 1);

    // R5 zero
    y_r = 8'h30; mem[8'h30] = 4'd5; b_r = 4'd4; c_r = 1;
    run_op(12'hF3D);
    chk(z_r == 1 && mem[8'h30] == 0, "R5 zero", {z_r, mem[8'h30]}, 8'h10);

    // R2 subtrahend is the destination itself
    x_r = 8'h40; mem[8'h40] = 4'd9; c_r = 1;
    run_op(12'hF3A);
    chk(mem[8'h40] == 4'hF && c_r == 1, "R2 self", mem[8'h40], 4'hF);

    // R2 X destination, M(Y) subtrahend
    x_r = 8'h21; y_r = 8'h20; mem[8'h21] = 4'd8; mem[8'h20] = 4'd3; c_r = 0;
    run_op(12'hF3B);
    chk(mem[8'h21] == 5 && mem[8'h20] == 3, "R2 cross", mem[8'h21], 5);

    // R1 out-of-range opcode ignored
    mem[8'h22] = 4'd6; x_r = 8'h22;
    run_op(12'hF37);
    chk(!busy && mem[8'h22] == 6 && x_r == 8'h22, "R1 ignore", mem[8'h22], 6);
    run_op(12'hF40);
    chk(x_r == 8'h22, "R1 ignore high", x_r, 8'h22);

    // R8 start while busy ignored
    x_r = 8'h60; mem[8'h60] = 4'd9; a_r = 1; c_r = 0; mem[8'h61] = 4'd9;
    @(negedge clk); opcode = 12'hF38; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    chk(x_r == 8'h61 && mem[8'h61] == 9, "R8 ignored start", x_r, 8'h61);

    // mixed patterns
    for (int k = 0; k < 40; k++) begin
      a_r = 4'(k * 5); b_r = 4'(k * 3 + 1);
      run_op(12'hF38 + 12'(k % 8));
    end

    summary();
  end
endmodule